// File: doc/BRIEF.md
# Hardwired Instruction Sequence Generator

This block stands in for a stored control routine. Instead of a program counter that reads instructions from memory, a small automaton presents one instruction at a time on its outputs: an opcode and an operand or jump address. Its state lives in two sets of flip-flops. The opcode set has one flop per distinct opcode and the address set has one flop per distinct address. One flop in each set is active at a time. Because each (opcode, address) pair occurs once in a routine, the pair names the current step.

Two routines are built in, and they share the same flops. A program-select input is sampled on a start pulse and chooses the routine. After that, the executing datapath steps the block with condition reports. A "finished" code moves a plain step to its successor. A sign code picks one of two successors at a branch step. Each routine ends in a terminal step that holds until the next start or reset.

Top module: `isg_sequencer`

## Requirements
- R1: While `rst_n` is low, the block is idle: `instr_valid_o`=0, `done_o`=0, `opcode_o`=0 and `addr_o`=0. This holds at once when reset asserts, even between clock edges.
- R2: The state is a 6-flop opcode set and an 8-flop address set. On every cycle each set is either all zero or one-hot, and the two sets are zero on the same cycles.
- R3: On a clock edge with `start_i` high, step 1 of routine `prog_sel_i` is loaded, and it appears on the outputs after that edge. `start_i` takes priority over any condition on the same edge and restarts the block from any state. `prog_sel_i` has no effect on any other cycle.
- R4: `opcode_o` is the index of the active opcode flop. `addr_o` is ADDR_BASE + index of the active address flop × ADDR_STRIDE (defaults 0x0100 and 4). Condition codes on `cond_code_i` are 0 = finished, 1 = sign positive, 2 = sign negative and 3 = reserved.
- R5: Routine 0 presents these (opcode, address index) pairs for steps 1..16: (0,0) (1,1) (2,2) (1,3) (3,1) (4,4) (0,1) (1,2) (2,3) (3,4) (0,5) (1,6) (3,2) (2,5) (4,7) (5,0).
- R6: In routine 0, every step other than 3, 9, 14 and 16 moves to the next step on code 0 and ignores codes 1 and 2. The branch steps move as follows: step 3 goes to 4 on code 1 and to 7 on code 2; step 9 goes to 10 on code 1 and to 13 on code 2; step 14 goes to 15 on code 1 and back to 11 on code 2. Branch steps ignore code 0.
- R7: Routine 1 presents these pairs for steps 1..10: (0,7) (1,1) (3,3) (2,6) (4,2) (0,2) (3,5) (1,4) (2,0) (5,5). Its plain steps move on code 0. Step 4 goes to 5 on code 1 and to 8 on code 2. Step 9 goes to 10 on code 1 and back to 2 on code 2.
- R8: The terminal step (16 in routine 0, 10 in routine 1) drives `done_o` high. The state holds under every condition until a start or reset.
- R9: While the block is idle, condition inputs leave it idle.
- R10: Code 3 with `cond_valid_i` high leaves the state unchanged in every step.
- R11: `instr_valid_o` is high in every non-idle step, including the terminal step. Each accepted condition moves exactly one step, and the outputs change on the edge that samples it. The active pair is always a step of the latched routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Load step 1 of the selected routine |
| prog_sel_i | input | 1 | Routine select, sampled with `start_i` |
| cond_valid_i | input | 1 | A condition report is present this cycle |
| cond_code_i | input | 2 | Condition code (finished, positive, negative, reserved) |
| instr_valid_o | output | 1 | An instruction is being presented |
| opcode_o | output | OP_W | Current opcode |
| addr_o | output | ADDR_W | Current operand or jump address |
| done_o | output | 1 | Terminal step reached |

## Verification
Directed walks go through each routine on the branch's first successor, then on its alternative. They include the backward loops from step 14 to 11 and from step 9 to 2, which show whether a revisited pair gives the same instruction again. Codes that do not belong to the step are sent in between: "finished" at a branch, a sign at a plain step, the reserved code, and reports while idle or done. These separate real transitions from stray ones. A start sent together with a condition, a change of select while running, and a random stream of starts and codes against a behavioural step-number model cover routine latching, start priority and the interleavings between them.

// File: rtl/isg_pkg.sv
package isg_pkg;

  localparam int unsigned NUM_OPS   = 6;
  localparam int unsigned NUM_ADRS  = 8;
  localparam int unsigned MAX_STEPS = 16;
  localparam int unsigned STEP_W    = $clog2(MAX_STEPS + 1);
  localparam int unsigned OPIDX_W   = $clog2(NUM_OPS);
  localparam int unsigned ADIDX_W   = $clog2(NUM_ADRS);

  typedef logic [STEP_W-1:0]   step_t;
  typedef logic [NUM_OPS-1:0]  op_set_t;
  typedef logic [NUM_ADRS-1:0] ad_set_t;

  typedef enum logic [1:0] {
    COND_FIN = 2'd0,
    COND_POS = 2'd1,
    COND_NEG = 2'd2,
    COND_RSV = 2'd3
  } cond_e;

  // Terminal step of each routine
  function automatic step_t last_step(input logic prog);
    return prog ? step_t'(10) : step_t'(16);
  endfunction

  // Opcode flop used by a step
  function automatic int unsigned op_of(input logic prog, input step_t s);
    int unsigned k;
    k = int'(s);
    if (!prog) begin
      case (k)
        1, 7, 11:    return 0;
        2, 4, 8, 12: return 1;
        3, 9, 14:    return 2;
        5, 10, 13:   return 3;
        6, 15:       return 4;
        default:     return 5;
      endcase
    end
    case (k)
      1, 6:    return 0;
      2, 8:    return 1;
      4, 9:    return 2;
      3, 7:    return 3;
      5:       return 4;
      default: return 5;
    endcase
  endfunction

  // Address flop used by a step
  function automatic int unsigned ad_of(input logic prog, input step_t s);
    int unsigned k;
    k = int'(s);
    if (!prog) begin
      case (k)
        2, 5, 7:  return 1;
        3, 8, 13: return 2;
        4, 9:     return 3;
        6, 10:    return 4;
        11, 14:   return 5;
        12:       return 6;
        15:       return 7;
        default:  return 0;
      endcase
    end
    case (k)
      1:       return 7;
      2:       return 1;
      3:       return 3;
      4:       return 6;
      5, 6:    return 2;
      7, 10:   return 5;
      8:       return 4;
      default: return 0;
    endcase
  endfunction

  // Alternative (negative-sign) successor; zero marks a plain step
  function automatic step_t alt_of(input logic prog, input step_t s);
    int unsigned k;
    k = int'(s);
    if (!prog) begin
      case (k)
        3:       return step_t'(7);
        9:       return step_t'(13);
        14:      return step_t'(11);
        default: return '0;
      endcase
    end
    case (k)
      4:       return step_t'(8);
      9:       return step_t'(2);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/isg_pair_decode.sv
module isg_pair_decode
  import isg_pkg::*;
(
  input  op_set_t op_set,
  input  ad_set_t ad_set,
  input  logic    prog,
  output step_t   step,
  output logic    legal
);

  logic [MAX_STEPS:1] hit;

  for (genvar s = 1; s <= MAX_STEPS; s++) begin : g_step
    localparam step_t S = step_t'(s);
    assign hit[s] = (S <= last_step(prog))
                 && (op_set == (op_set_t'(1) << op_of(prog, S)))
                 && (ad_set == (ad_set_t'(1) << ad_of(prog, S)));
  end

  always_comb begin
    step = '0;
    for (int s = 1; s <= MAX_STEPS; s++) begin
      if (hit[s]) step = step | step_t'(s);
    end
  end

  assign legal = |hit;

endmodule

// File: rtl/isg_succ.sv
module isg_succ
  import isg_pkg::*;
(
  input  step_t      step,
  input  logic       prog,
  input  logic       cond_valid,
  input  logic [1:0] cond_code,
  output step_t      nxt,
  output logic       adv
);

  step_t alt;
  logic  live;

  assign alt  = alt_of(prog, step);
  assign live = cond_valid && (step != '0) && (step != last_step(prog));

  always_comb begin
    nxt = step;
    adv = 1'b0;
    if (live) begin
      if (alt != '0) begin
        if (cond_code == COND_POS) begin
          nxt = step_t'(step + 1'b1);
          adv = 1'b1;
        end else if (cond_code == COND_NEG) begin
          nxt = alt;
          adv = 1'b1;
        end
      end else if (cond_code == COND_FIN) begin
        nxt = step_t'(step + 1'b1);
        adv = 1'b1;
      end
    end
  end

endmodule

// File: rtl/isg_pair_encode.sv
module isg_pair_encode
  import isg_pkg::*;
(
  input  step_t   step,
  input  logic    prog,
  output op_set_t op_set,
  output ad_set_t ad_set
);

  logic in_range;

  assign in_range = (step != '0) && (step <= last_step(prog));

  always_comb begin
    op_set = '0;
    ad_set = '0;
    if (in_range) begin
      op_set = op_set_t'(1) << op_of(prog, step);
      ad_set = ad_set_t'(1) << ad_of(prog, step);
    end
  end

endmodule

// File: rtl/isg_out_map.sv
module isg_out_map
  import isg_pkg::*;
#(
  parameter int unsigned       OP_W        = 3,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] ADDR_BASE   = 16'h0100,
  parameter logic [ADDR_W-1:0] ADDR_STRIDE = 16'h0004
) (
  input  op_set_t           op_set,
  input  ad_set_t           ad_set,
  output logic              active,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] addr
);

  logic [ADIDX_W-1:0] ad_idx;

  assign active = |op_set;

  always_comb begin
    opcode = '0;
    for (int i = 0; i < int'(NUM_OPS); i++) begin
      if (op_set[i]) opcode = opcode | OP_W'(i);
    end
  end

  always_comb begin
    ad_idx = '0;
    for (int i = 0; i < int'(NUM_ADRS); i++) begin
      if (ad_set[i]) ad_idx = ad_idx | ADIDX_W'(i);
    end
  end

  assign addr = active ? ADDR_BASE + (ADDR_W'(ad_idx) * ADDR_STRIDE) : '0;

endmodule

// File: rtl/isg_sequencer.sv
module isg_sequencer
  import isg_pkg::*;
#(
  parameter int unsigned       OP_W        = 3,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] ADDR_BASE   = 16'h0100,
  parameter logic [ADDR_W-1:0] ADDR_STRIDE = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              prog_sel_i,
  input  logic              cond_valid_i,
  input  logic [1:0]        cond_code_i,
  output logic              instr_valid_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  op_set_t op_q, op_d;
  ad_set_t ad_q, ad_d;
  logic    prog_q, prog_d;
  logic    load_en;

  step_t   cur_step;
  logic    cur_legal;
  step_t   succ_step;
  logic    succ_adv;
  step_t   enc_step;

  // Current step from the active pair
  isg_pair_decode u_decode (
    .op_set (op_q),
    .ad_set (ad_q),
    .prog   (prog_q),
    .step   (cur_step),
    .legal  (cur_legal)
  );

  // Successor chosen by the condition report
  isg_succ u_succ (
    .step       (cur_step),
    .prog       (prog_q),
    .cond_valid (cond_valid_i),
    .cond_code  (cond_code_i),
    .nxt        (succ_step),
    .adv        (succ_adv)
  );

  // Start has priority and selects step 1 of the sampled routine
  assign enc_step = start_i ? step_t'(1) : succ_step;
  assign prog_d   = start_i ? prog_sel_i : prog_q;
  assign load_en  = start_i | succ_adv;

  isg_pair_encode u_encode (
    .step   (enc_step),
    .prog   (prog_d),
    .op_set (op_d),
    .ad_set (ad_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      ad_q   <= '0;
      prog_q <= 1'b0;
    end else if (load_en) begin
      op_q   <= op_d;
      ad_q   <= ad_d;
      prog_q <= prog_d;
    end
  end

  isg_out_map #(
    .OP_W        (OP_W),
    .ADDR_W      (ADDR_W),
    .ADDR_BASE   (ADDR_BASE),
    .ADDR_STRIDE (ADDR_STRIDE)
  ) u_out (
    .op_set (op_q),
    .ad_set (ad_q),
    .active (instr_valid_o),
    .opcode (opcode_o),
    .addr   (addr_o)
  );

  assign done_o = cur_legal && (cur_step == last_step(prog_q));

  // R2: each set is idle or one-hot, and the two sets go idle together
  a_r2_op_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_q));
  a_r2_ad_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ad_q));
  a_r2_sets_paired: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_q == '0) == (ad_q == '0)));

  // R11: an active pair always names a step of the latched routine
  a_r11_pair_is_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != '0) |-> cur_legal);

  // R3: start loads step 1
  a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cur_step == step_t'(1)));

  // R8: terminal step holds without a start
  a_r8_terminal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(op_q) && $stable(ad_q)));

  // R9: idle stays idle without a start
  a_r9_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_q == '0) && !start_i) |=> (op_q == '0));

  // R10: reserved code leaves the state alone
  a_r10_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_valid_i && (cond_code_i == COND_RSV) && !start_i)
      |=> ($stable(op_q) && $stable(ad_q)));

endmodule

// File: tb/test_isg_sequencer.sv
`timescale 1ns/1ps
module test_isg_sequencer;

  localparam int unsigned OP_W   = 3;
  localparam int unsigned ADDR_W = 16;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              sel;
  logic              cv;
  logic [1:0]        code;
  logic              vld;
  logic [OP_W-1:0]   opc;
  logic [ADDR_W-1:0] adr;
  logic              done;

  isg_sequencer i_isg_sequencer (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .prog_sel_i    (sel),
    .cond_valid_i  (cv),
    .cond_code_i   (code),
    .instr_valid_o (vld),
    .opcode_o      (opc),
    .addr_o        (adr),
    .done_o        (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int unsigned p0_op [16] = '{0,1,2,1,3,4,0,1,2,3,0,1,3,2,4,5};
  int unsigned p0_ad [16] = '{0,1,2,3,1,4,1,2,3,4,5,6,2,5,7,0};
  int unsigned p1_op [10] = '{0,1,3,2,4,0,3,1,2,5};
  int unsigned p1_ad [10] = '{7,1,3,6,2,2,5,4,0,5};

  int    m_st;
  bit    m_prog;
  string tag;
  int    n_chk;
  int    n_fail;

  function automatic int m_last();
    return m_prog ? 10 : 16;
  endfunction

  function automatic int m_next(int st, int c);
    int alt;
    alt = 0;
    if (!m_prog) begin
      if (st == 3)  alt = 7;
      if (st == 9)  alt = 13;
      if (st == 14) alt = 11;
    end else begin
      if (st == 4) alt = 8;
      if (st == 9) alt = 2;
    end
    if (alt != 0) begin
      if (c == 1) return st + 1;
      if (c == 2) return alt;
      return st;
    end
    return (c == 0) ? st + 1 : st;
  endfunction

  task automatic check(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s step=%0d act=%0d exp=%0d", tag, what, m_st, act, exp);
    end
  endtask

  task automatic chk_out();
    int e_op, e_ad;
    e_op = 0;
    e_ad = 0;
    if (m_st != 0) begin
      e_op = m_prog ? p1_op[m_st-1] : p0_op[m_st-1];
      e_ad = m_prog ? p1_ad[m_st-1] : p0_ad[m_st-1];
    end
    check("valid", vld, (m_st != 0) ? 1 : 0);
    check("done", done, (m_st != 0 && m_st == m_last()) ? 1 : 0);
    check("opcode", opc, e_op);
    check("addr", adr, (m_st != 0) ? 16'h0100 + e_ad * 4 : 0);
  endtask

  // Called just after a falling edge; checks at the next falling edge
  task automatic cyc(input bit s, input bit p, input bit v, input logic [1:0] c);
    start = s;
    sel   = p;
    cv    = v;
    code  = c;
    @(posedge clk);
    if (s) begin
      m_st   = 1;
      m_prog = p;
    end else if (v && m_st != 0 && m_st != m_last()) begin
      m_st = m_next(m_st, int'(c));
    end
    @(negedge clk);
    chk_out();
  endtask

  task automatic fins(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, ~m_prog, 1'b1, 2'd0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    m_st = 0;
    m_prog = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    sel = 1'b0;
    cv = 1'b0;
    code = 2'd0;
    tag = "R1";
    repeat (3) @(negedge clk);
    chk_out();
    rst_n = 1'b1;

    tag = "R9";
    cyc(0, 0, 1, 2'd0);
    cyc(0, 1, 1, 2'd1);
    cyc(0, 0, 1, 2'd2);

    tag = "R3";
    cyc(1, 0, 0, 2'd0);
    tag = "R5";
    fins(2);
    tag = "R6";
    cyc(0, 0, 1, 2'd0);
    cyc(0, 0, 1, 2'd1);
    tag = "R5";
    fins(5);
    tag = "R6";
    cyc(0, 0, 1, 2'd1);
    fins(4);
    cyc(0, 0, 1, 2'd2);
    fins(3);
    cyc(0, 0, 1, 2'd1);
    cyc(0, 0, 1, 2'd2);
    tag = "R10";
    cyc(0, 0, 1, 2'd3);
    cyc(0, 0, 0, 2'd0);
    tag = "R11";
    fins(1);
    tag = "R8";
    cyc(0, 0, 1, 2'd0);
    cyc(0, 0, 1, 2'd1);
    cyc(0, 0, 1, 2'd2);
    cyc(0, 0, 1, 2'd3);

    tag = "R3";
    cyc(1, 0, 1, 2'd0);
    tag = "R6";
    fins(2);
    cyc(0, 0, 1, 2'd2);
    fins(2);
    cyc(0, 0, 1, 2'd2);
    fins(3);

    tag = "R7";
    cyc(1, 1, 0, 2'd0);
    fins(3);
    cyc(0, 1, 1, 2'd0);
    cyc(0, 1, 1, 2'd2);
    fins(1);
    cyc(0, 1, 1, 2'd2);
    fins(2);
    cyc(0, 1, 1, 2'd1);
    tag = "R10";
    cyc(0, 1, 1, 2'd3);
    tag = "R7";
    fins(4);
    cyc(0, 1, 1, 2'd1);
    tag = "R8";
    cyc(0, 0, 1, 2'd2);
    cyc(0, 0, 1, 2'd0);

    tag = "R4";
    cyc(1, 0, 0, 2'd0);
    fins(14);
    tag = "R3";
    cyc(1, 1, 1, 2'd0);
    cyc(1, 0, 1, 2'd2);

    tag = "R11";
    for (int k = 0; k < 800; k++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 3, 1'($urandom_range(0, 1)), (r % 4) != 0, 2'($urandom_range(0, 3)));
    end

    tag = "R1";
    cyc(1, 1, 0, 2'd0);
    fins(2);
    rst_n = 1'b0;
    #1;
    m_st = 0;
    chk_out();
    @(negedge clk);
    chk_out();
    rst_n = 1'b1;
    tag = "R9";
    cyc(0, 0, 1, 2'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog run did not finish act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule